// File: doc/BRIEF.md
# SOM Learning-Rate and Radius Scheduler

This block supplies the two training coefficients that a self-organizing map needs at every epoch: the learning rate and the neighbourhood radius. It keeps its own epoch counter, which moves forward by one each time the surrounding training controller pulses `epoch_tick`. The rate and radius for the current epoch are shown at the outputs, together with a flag that tells which training phase is active.

Training has two phases. During the ordering phase, up to epoch 1000, the learning rate falls in a straight line from 0.9 to about 0.02. The radius falls the same way from a starting value set by the map size down to 1. From epoch 1000 on, in the tuning phase, the learning rate follows a five-piece linear curve that approximates an inverse-time decay, and the radius stays at 1. Neither phase needs a run-time divider. The ordering ramps are stepped with remainder accumulators. The tuning curve is one multiply by a constant from a small coefficient table. The counter stops at epoch 10000, and all outputs then stay where they are.

The outputs are level values, not a data stream, so there is no valid/ready pair and no back-pressure. A consumer may read them in any cycle, and they change only on a clock edge that takes a tick or applies the synchronous reset.

Top module: `som_sched`

## Requirements
- R1: `srst` high at a clock edge sets the epoch count to 0, and this wins over an `epoch_tick` in the same cycle. With `srst` low, each clock edge that sees `epoch_tick` high and a count below 10000 raises the count by exactly 1.
- R2: Once the count reaches 10000, further ticks are ignored: `epoch_o`, `alpha_o`, `radius_o` and `tuning_o` keep their values until reset.
- R3: `tuning_o` is 1 exactly when `epoch_o` is 1000 or more, and 0 below that.
- R4: In the ordering phase (epoch t < 1000), `alpha_o` is unsigned Q1.15 and equals 29491 − floor(t·28836/1000). It starts at 29491 (0.9) and moves toward 655 (0.02).
- R5: In the tuning phase, `alpha_o` = A − floor(B·t/65536). The segment is chosen by the largest start epoch not above t. The (start, A, B) triples are (1000, 1075, 27488), (1562, 727, 12949), (2125, 511, 6228), (3250, 321, 2405) and (5500, 184, 773).
- R6: In the ordering phase, `radius_o` = R0 − floor(t·(R0−1)/1000), where R0 = ceil(sqrt((ROWS−1)² + (COLS−1)²)), with a minimum of 1. For the default 5×5 map, R0 is 6.
- R7: In the tuning phase, `radius_o` is 1.
- R8: All outputs take their new values at the same clock edge that changes the count. An edge with `epoch_tick` low (and no reset) leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| epoch_tick | input | 1 | One-cycle pulse that advances the epoch |
| epoch_o | output | $clog2(T_MAX+1) (14) | Current epoch count |
| alpha_o | output | 16 | Learning rate, unsigned Q1.15 |
| radius_o | output | RW (3 for 5×5) | Neighbourhood radius in map cells |
| tuning_o | output | 1 | 1 in the tuning phase, 0 in the ordering phase |

## Verification
Two functions can act in the same cycle: the synchronous reset and an epoch advance. They are provoked together twice, once early in the run and once after the counter has saturated at 10000. Reset must win both times: the next sample must show epoch 0, rate 29491 and radius 6, and must not show epoch 1 or the held saturated values. A second case is the phase change. The tick that moves the count from 999 to 1000 also switches the rate source and the radius source in the same edge. The sample taken right after that edge is compared with the tuning-phase formulas, not the ordering ones.

// File: rtl/som_sched_pkg.sv
package som_sched_pkg;

  localparam int ALPHA_W     = 16;
  localparam int NSEG        = 5;
  localparam int SLOPE_SHIFT = 16;
  localparam int ALPHA_START = 29491;  // 0.9 in Q1.15
  localparam int ALPHA_KNEE  = 655;    // 0.02 in Q1.15

  typedef logic [ALPHA_W-1:0] alpha_t;

  typedef struct packed {
    logic [13:0] first_ep;
    logic [15:0] icpt;
    logic [15:0] slope;
  } seg_t;

  // Tuning-phase segments: rate = icpt - (slope * t) >> 16
  function automatic seg_t seg_coef(input int idx);
    seg_t s;
    case (idx)
      0:       s = '{first_ep: 14'd1000, icpt: 16'd1075, slope: 16'd27488};
      1:       s = '{first_ep: 14'd1562, icpt: 16'd727,  slope: 16'd12949};
      2:       s = '{first_ep: 14'd2125, icpt: 16'd511,  slope: 16'd6228};
      3:       s = '{first_ep: 14'd3250, icpt: 16'd321,  slope: 16'd2405};
      default: s = '{first_ep: 14'd5500, icpt: 16'd184,  slope: 16'd773};
    endcase
    return s;
  endfunction

  function automatic int ceil_sqrt(input int v);
    int r;
    r = 0;
    for (int k = 0; k <= v; k++) begin
      if (k * k < v) r = k + 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/som_epoch_ctr.sv
module som_epoch_ctr #(
  parameter int T_MAX = 10000,
  parameter int EW    = $clog2(T_MAX + 1)
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          tick,
  output logic [EW-1:0] epoch,
  output logic          adv
);
  logic [EW-1:0] cnt_q;

  assign adv   = tick && (cnt_q != EW'(T_MAX));
  assign epoch = cnt_q;

  always_ff @(posedge clk) begin
    if (srst)     cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + EW'(1);
  end
endmodule

// File: rtl/som_lin_ramp.sv
module som_lin_ramp #(
  parameter int VW    = 16,
  parameter int START = 0,
  parameter int DROP  = 0,
  parameter int SPAN  = 1
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          step,
  output logic [VW-1:0] value
);
  localparam int QUO = DROP / SPAN;
  localparam int REM = DROP % SPAN;
  localparam int RMW = $clog2(SPAN + 1);

  logic [VW-1:0]  val_q;
  logic [RMW-1:0] rem_q, rem_nx;
  logic [RMW:0]   rem_sum;
  logic           carry;
  logic [VW-1:0]  dec;

  always_comb begin
    rem_sum = {1'b0, rem_q} + (RMW+1)'(REM);
    carry   = (rem_sum >= (RMW+1)'(SPAN));
    rem_nx  = carry ? RMW'(rem_sum - (RMW+1)'(SPAN)) : RMW'(rem_sum);
    dec     = VW'(QUO) + VW'(carry);
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      val_q <= VW'(START);
      rem_q <= '0;
    end else if (step) begin
      val_q <= val_q - dec;
      rem_q <= rem_nx;
    end
  end

  assign value = val_q;
endmodule

// File: rtl/som_pwl_decay.sv
module som_pwl_decay
  import som_sched_pkg::*;
#(
  parameter int EW = 14
) (
  input  logic [EW-1:0] epoch,
  output alpha_t        rate
);
  localparam int PW = ALPHA_W + EW;

  logic [NSEG-1:0] hit;
  seg_t            sel;
  logic [PW-1:0]   prod;
  logic [PW-1:0]   drop;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam seg_t S = seg_coef(g);
    assign hit[g] = (32'(epoch) >= 32'(S.first_ep));
  end

  always_comb begin
    sel = seg_coef(0);
    for (int i = 0; i < NSEG; i++) begin
      if (hit[i]) sel = seg_coef(i);
    end
    prod = PW'(sel.slope) * PW'(epoch);
    drop = prod >> SLOPE_SHIFT;
    rate = sel.icpt - drop[ALPHA_W-1:0];
  end
endmodule

// File: rtl/som_sched.sv
module som_sched
  import som_sched_pkg::*;
#(
  parameter int ROWS  = 5,
  parameter int COLS  = 5,
  parameter int TAU   = 1000,
  parameter int T_MAX = 10000,
  localparam int EW     = $clog2(T_MAX + 1),
  localparam int R0_RAW = ceil_sqrt((ROWS - 1) * (ROWS - 1) + (COLS - 1) * (COLS - 1)),
  localparam int R0     = (R0_RAW < 1) ? 1 : R0_RAW,
  localparam int RW     = $clog2(R0 + 1)
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          epoch_tick,
  output logic [EW-1:0] epoch_o,
  output logic [15:0]   alpha_o,
  output logic [RW-1:0] radius_o,
  output logic          tuning_o
);
  logic [EW-1:0] epoch;
  logic          adv;
  logic          ord_step;
  alpha_t        alpha_ord;
  alpha_t        alpha_tun;
  logic [RW-1:0] rad_ord;
  logic          tuning;

  som_epoch_ctr #(.T_MAX(T_MAX), .EW(EW)) ctr_i (
    .clk(clk), .srst(srst), .tick(epoch_tick), .epoch(epoch), .adv(adv)
  );

  assign tuning   = (epoch >= EW'(TAU));
  assign ord_step = adv && !tuning;

  som_lin_ramp #(
    .VW(ALPHA_W), .START(ALPHA_START), .DROP(ALPHA_START - ALPHA_KNEE), .SPAN(TAU)
  ) alpha_ramp_i (
    .clk(clk), .srst(srst), .step(ord_step), .value(alpha_ord)
  );

  som_lin_ramp #(
    .VW(RW), .START(R0), .DROP(R0 - 1), .SPAN(TAU)
  ) radius_ramp_i (
    .clk(clk), .srst(srst), .step(ord_step), .value(rad_ord)
  );

  som_pwl_decay #(.EW(EW)) pwl_i (
    .epoch(epoch), .rate(alpha_tun)
  );

  assign epoch_o  = epoch;
  assign tuning_o = tuning;
  assign alpha_o  = tuning ? alpha_tun : alpha_ord;
  assign radius_o = tuning ? RW'(1) : rad_ord;
endmodule

// File: rtl/som_sched_chk.sv
module som_sched_chk #(
  parameter int TAU   = 1000,
  parameter int T_MAX = 10000,
  parameter int EW    = 14,
  parameter int RW    = 3,
  parameter int R0    = 6
) (
  input logic          clk,
  input logic          srst,
  input logic          epoch_tick,
  input logic [EW-1:0] epoch_o,
  input logic [15:0]   alpha_o,
  input logic [RW-1:0] radius_o,
  input logic          tuning_o
);
  logic armed;
  initial armed = 1'b0;
  always @(posedge clk) if (srst) armed <= 1'b1;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    srst |=> (epoch_o == '0 && alpha_o == 16'd29491 && radius_o == RW'(R0) && !tuning_o));

  // R1
  epoch_step_chk: assert property (@(posedge clk) disable iff (srst || !armed)
    (epoch_tick && epoch_o != EW'(T_MAX)) |=> (epoch_o == $past(epoch_o) + EW'(1)));

  // R2
  saturate_chk: assert property (@(posedge clk) disable iff (srst || !armed)
    (epoch_o == EW'(T_MAX)) |=> ($stable(epoch_o) && $stable(alpha_o) && $stable(radius_o)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (srst || !armed)
    !epoch_tick |=> ($stable(epoch_o) && $stable(alpha_o) && $stable(radius_o) && $stable(tuning_o)));

  // R3
  phase_flag_chk: assert property (@(posedge clk) disable iff (srst || !armed)
    tuning_o == (epoch_o >= EW'(TAU)));

  // R7
  tune_radius_chk: assert property (@(posedge clk) disable iff (srst || !armed)
    tuning_o |-> (radius_o == RW'(1)));

  // R4
  order_alpha_range_chk: assert property (@(posedge clk) disable iff (srst || !armed)
    !tuning_o |-> (alpha_o <= 16'd29491 && alpha_o > 16'd655));
endmodule

bind som_sched som_sched_chk #(
  .TAU(TAU), .T_MAX(T_MAX), .EW(EW), .RW(RW), .R0(R0)
) chk_i (
  .clk(clk), .srst(srst), .epoch_tick(epoch_tick), .epoch_o(epoch_o),
  .alpha_o(alpha_o), .radius_o(radius_o), .tuning_o(tuning_o)
);

// File: tb/som_sched_tb_top.sv
module som_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAU   = 1000;
  localparam int T_MAX = 10000;
  localparam int R0    = 6;

  logic        clk = 1'b0;
  logic        srst = 1'b1;
  logic        epoch_tick = 1'b0;
  logic [13:0] epoch_o;
  logic [15:0] alpha_o;
  logic [2:0]  radius_o;
  logic        tuning_o;

  typedef struct {
    int ep;
    int al;
    int rd;
    bit tu;
  } exp_t;

  exp_t sbq[$];
  int   total = 0;
  int   bad = 0;
  int   model_ep = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  som_sched dut_i (
    .clk(clk), .srst(srst), .epoch_tick(epoch_tick), .epoch_o(epoch_o),
    .alpha_o(alpha_o), .radius_o(radius_o), .tuning_o(tuning_o)
  );

  function automatic int alpha_ref(input int t);
    int st[5] = '{1000, 1562, 2125, 3250, 5500};
    int aa[5] = '{1075, 727, 511, 321, 184};
    int bb[5] = '{27488, 12949, 6228, 2405, 773};
    int k;
    if (t < TAU) return 29491 - (t * 28836) / 1000;
    k = 0;
    for (int i = 0; i < 5; i++) if (t >= st[i]) k = i;
    return aa[k] - (bb[k] * t) / 65536;
  endfunction

  function automatic int radius_ref(input int t);
    if (t < TAU) return R0 - (t * (R0 - 1)) / 1000;
    return 1;
  endfunction

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic cycle(input bit rst, input bit tick);
    exp_t e;
    @(negedge clk);
    srst = rst;
    epoch_tick = tick;
    if (rst) model_ep = 0;
    else if (tick && model_ep < T_MAX) model_ep++;
    e.ep = model_ep;
    e.al = alpha_ref(model_ep);
    e.rd = radius_ref(model_ep);
    e.tu = (model_ep >= TAU);
    sbq.push_back(e);
  endtask

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: epoch model %0d actual=%0d expected=%0d", req, model_ep, act, expv);
    end
  endtask

  // monitor: compares after each active edge
  always begin
    exp_t e;
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      check((e.ep == T_MAX) ? "R2" : "R1", int'(epoch_o), e.ep);
      check(e.tu ? "R5" : "R4", int'(alpha_o), e.al);
      check(e.tu ? "R7" : "R6", int'(radius_o), e.rd);
      check("R3", int'(tuning_o), int'(e.tu));
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state, reset wins over a coincident tick
    cycle(1, 0);
    cycle(1, 1);
    cycle(1, 0);
    // R8: idle edges change nothing
    cycle(0, 0);
    cycle(0, 0);
    // R1 R4 R6: sparse ticks
    for (int i = 0; i < 60; i++) cycle(0, (i % 2) == 0);
    // R1 reset mid-ramp together with tick
    cycle(1, 1);
    cycle(0, 0);
    // dense ticks through the phase switch (R3) and all segments (R5, R7)
    for (int i = 0; i < T_MAX; i++) cycle(0, 1);
    // R2: saturated, further ticks ignored
    for (int i = 0; i < 6; i++) cycle(0, 1);
    cycle(0, 0);
    // R1: reset with tick after saturation
    cycle(1, 1);
    cycle(0, 1);
    cycle(0, 0);
    @(negedge clk);
    epoch_tick = 1'b0;
    while (sbq.size() > 0) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule